// File: doc/BRIEF.md
# Fixed-Point Convolution Window Engine

This block computes one output feature map of a convolution layer from a single square input plane held in its own local memory. Software or a loader first writes the plane pixel by pixel and writes the K×K mask coefficients and one bias into local registers. A start pulse then launches a scan. The engine slides the mask over the plane with stride 1, one multiply per clock. Each product is rescaled back to the working fixed-point format before it is added. At the end of each window the engine adds the bias, clamps the sum and applies a rectifier. It emits the result together with the column and row of the window.

All values are 32-bit two's complement numbers scaled by 2^10. The plane side N and the mask size K are parameters, so one instance can run a 5×5 mask and another a 4×4 mask. No external memory is touched while a scan runs. Windows are visited row by row, left to right within a row. A done pulse marks the end of the map.

Top module: `conv_window_engine`

## Requirements
- R1: Pixels, coefficients, bias and results are 32-bit signed with 10 fractional bits; each pixel×coefficient product is arithmetically shifted right by 10 (rounding toward minus infinity, so a product of -1 becomes -1) before it is added.
- R2: The result for window (x,y) is bias plus the sum over u,v in [0,K-1] of the rescaled product of the pixel at plane address (y+u)·N+(x+v) and the coefficient at coefficient address u·K+v; the bias is written at coefficient address K·K.
- R3: The running sum starts at the bias and takes the taps in order of u, then v; after every addition it is clamped to [-2^31, 2^31-1] rather than wrapping.
- R4: A clamped window sum below zero is output as 0; any other sum is output unchanged.
- R5: The engine produces exactly (N-K+1)^2 results per start, in raster order: out_x runs from 0 to N-K within a row, then out_y advances; out_valid is high for one cycle per result.
- R6: done is high for exactly one cycle, the cycle right after the last result's out_valid; busy is high from the cycle after an accepted start until done rises.
- R7: A start pulse while busy is high is ignored: the running scan continues with the same results and a single done.
- R8: After reset, out_valid, done and busy are low.
- R9: With K=4 the same engine maps a 13×13 plane to a 10×10 result map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| pix_we | input | 1 | Plane write enable |
| pix_addr | input | clog2(N·N) | Plane write address, row·N+column |
| pix_data | input | 32 | Plane write data |
| coef_we | input | 1 | Coefficient/bias write enable |
| coef_addr | input | clog2(K·K+1) | u·K+v for a coefficient, K·K for the bias |
| coef_data | input | 32 | Coefficient/bias write data |
| start | input | 1 | Start pulse for one map |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-map pulse |
| out_valid | output | 1 | Result valid |
| out_x | output | clog2(N) | Result column |
| out_y | output | clog2(N) | Result row |
| out_data | output | 32 | Rectified result |

## Verification
A wrong tap counter or address shows up in the very first window as a result that departs from the model, and it stays wrong for every later window. A lost clamp appears as a huge negative or small result on planes filled with extreme values. It shows on the first window whose partial sum crosses the range. An error in the window counters shows at the first row wrap as a wrong out_x or out_y. At the end it shows as a wrong result count or a done pulse that is misplaced relative to the last out_valid. Directed cases with a single nonzero coefficient expose the shift direction and rounding within one window.

// File: rtl/conv_window_engine.sv
module conv_window_engine #(
  parameter int DW   = 32,
  parameter int FRAC = 10,
  parameter int N    = 16,
  parameter int K    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pix_we,
  input  logic [$clog2(N*N)-1:0]       pix_addr,
  input  logic [DW-1:0]                pix_data,
  input  logic                         coef_we,
  input  logic [$clog2(K*K+1)-1:0]     coef_addr,
  input  logic [DW-1:0]                coef_data,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic                         out_valid,
  output logic [$clog2(N)-1:0]         out_x,
  output logic [$clog2(N)-1:0]         out_y,
  output logic [DW-1:0]                out_data
);
  localparam int NPIX = N * N;
  localparam int KK   = K * K;
  localparam int OW   = N - K + 1;
  localparam int AW   = $clog2(NPIX);
  localparam int CAW  = $clog2(KK + 1);
  localparam int XW   = $clog2(N);
  localparam int KW   = (K > 1) ? $clog2(K) : 1;
  localparam logic signed [2*DW:0] SMAX = {{(DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [2*DW:0] SMIN = {{(DW+2){1'b1}}, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  logic signed [DW-1:0] plane [NPIX];
  logic signed [DW-1:0] wts   [KK];
  logic signed [DW-1:0] bias;

  st_t                  st;
  logic [XW-1:0]        ox, oy;
  logic [KW-1:0]        u, v;
  logic signed [DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (pix_we) plane[pix_addr] <= pix_data;
    if (coef_we) begin
      if (int'(coef_addr) == KK) bias <= coef_data;
      else if (int'(coef_addr) < KK) wts[coef_addr] <= coef_data;
    end
  end

  logic [AW-1:0]          pix_idx;
  logic [CAW-1:0]         wt_idx;
  logic signed [2*DW-1:0] prod, scaled;
  logic signed [2*DW:0]   sum;
  logic signed [DW-1:0]   acc_nx, relu;
  logic                   last_tap, last_win;

  assign pix_idx  = AW'((int'(oy) + int'(u)) * N + int'(ox) + int'(v));
  assign wt_idx   = CAW'(int'(u) * K + int'(v));
  assign prod     = plane[pix_idx] * wts[wt_idx];
  assign scaled   = prod >>> FRAC;
  assign sum      = {{(DW+1){acc[DW-1]}}, acc} + {scaled[2*DW-1], scaled};
  assign acc_nx   = (sum > SMAX) ? SMAX[DW-1:0] : (sum < SMIN) ? SMIN[DW-1:0] : sum[DW-1:0];
  assign relu     = acc_nx[DW-1] ? '0 : acc_nx;
  assign last_tap = (u == KW'(K-1)) && (v == KW'(K-1));
  assign last_win = (ox == XW'(OW-1)) && (oy == XW'(OW-1));
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ox <= '0; oy <= '0; u <= '0; v <= '0;
      acc <= '0;
      out_valid <= 1'b0; done <= 1'b0;
      out_x <= '0; out_y <= '0; out_data <= '0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN;
          ox <= '0; oy <= '0; u <= '0; v <= '0;
          acc <= bias;
        end
        S_RUN: if (!last_tap) begin
          acc <= acc_nx;
          if (v == KW'(K-1)) begin
            v <= '0;
            u <= u + 1'b1;
          end else begin
            v <= v + 1'b1;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= relu;
          out_x     <= ox;
          out_y     <= oy;
          acc       <= bias;
          u <= '0; v <= '0;
          if (last_win) st <= S_FIN;
          else if (ox == XW'(OW-1)) begin
            ox <= '0;
            oy <= oy + 1'b1;
          end else begin
            ox <= ox + 1'b1;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  a_r4_relu_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[DW-1]);

  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x <= XW'(OW-1)) && (out_y <= XW'(OW-1)));

  a_r5_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid) && ($past(out_x) == XW'(OW-1)) && ($past(out_y) == XW'(OW-1)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

endmodule

// File: tb/conv_window_engine_tb.sv
module conv_window_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 16, KA = 5, OWA = NA - KA + 1;
  localparam int NB = 13, KB = 4, OWB = NB - KB + 1;
  localparam int LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic a_pwe = 0, a_cwe = 0, a_start = 0;
  logic [$clog2(NA*NA)-1:0] a_paddr = '0;
  logic [$clog2(KA*KA+1)-1:0] a_caddr = '0;
  logic [31:0] a_pdata = '0, a_cdata = '0, a_odata;
  logic a_busy, a_done, a_ov;
  logic [$clog2(NA)-1:0] a_ox, a_oy;

  logic b_pwe = 0, b_cwe = 0, b_start = 0;
  logic [$clog2(NB*NB)-1:0] b_paddr = '0;
  logic [$clog2(KB*KB+1)-1:0] b_caddr = '0;
  logic [31:0] b_pdata = '0, b_cdata = '0, b_odata;
  logic b_busy, b_done, b_ov;
  logic [$clog2(NB)-1:0] b_ox, b_oy;

  conv_window_engine #(.N(NA), .K(KA)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_we(a_pwe), .pix_addr(a_paddr), .pix_data(a_pdata),
    .coef_we(a_cwe), .coef_addr(a_caddr), .coef_data(a_cdata), .start(a_start),
    .busy(a_busy), .done(a_done), .out_valid(a_ov), .out_x(a_ox), .out_y(a_oy), .out_data(a_odata));

  conv_window_engine #(.N(NB), .K(KB)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .pix_we(b_pwe), .pix_addr(b_paddr), .pix_data(b_pdata),
    .coef_we(b_cwe), .coef_addr(b_caddr), .coef_data(b_cdata), .start(b_start),
    .busy(b_busy), .done(b_done), .out_valid(b_ov), .out_x(b_ox), .out_y(b_oy), .out_data(b_odata));

  int n_chk = 0, n_bad = 0;
  string tag = "R2";

  task automatic check(string t, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", t, got, exp);
    end
  endtask

  int sa_p [NA*NA]; int sa_w [KA*KA]; int sa_b;
  int sb_p [NB*NB]; int sb_w [KB*KB]; int sb_b;

  function automatic int model(bit sel, int x, int y);
    int n = sel ? NB : NA;
    int k = sel ? KB : KA;
    longint s = sel ? sb_b : sa_b;
    for (int u = 0; u < k; u++)
      for (int v = 0; v < k; v++) begin
        longint p = sel ? sb_p[(y+u)*n + x+v] : sa_p[(y+u)*n + x+v];
        longint w = sel ? sb_w[u*k+v] : sa_w[u*k+v];
        s = s + ((p * w) >>> 10);
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
      end
    return (s < 0) ? 0 : int'(s);
  endfunction

  int a_cnt = 0, a_nd = 0, b_cnt = 0, b_nd = 0;
  logic a_pv = 0, b_pv = 0;

  always @(negedge clk) begin
    if (a_ov) begin
      check({"R5 x ", tag}, a_ox, a_cnt % OWA);
      check({"R5 y ", tag}, a_oy, a_cnt / OWA);
      check(tag, a_odata, model(0, a_cnt % OWA, a_cnt / OWA));
      a_cnt++;
    end
    if (a_done) begin
      a_nd++;
      check("R6 done after last valid", {a_pv, 31'(a_cnt)}, {1'b1, 31'(OWA*OWA)});
    end
    a_pv = a_ov;
    if (b_ov) begin
      check({"R9 x ", tag}, b_ox, b_cnt % OWB);
      check({"R9 y ", tag}, b_oy, b_cnt / OWB);
      check({"R9 ", tag}, b_odata, model(1, b_cnt % OWB, b_cnt / OWB));
      b_cnt++;
    end
    if (b_done) begin
      b_nd++;
      check("R9 R6 done after last valid", {b_pv, 31'(b_cnt)}, {1'b1, 31'(OWB*OWB)});
    end
    b_pv = b_ov;
  end

  // mode 0 small random, 1 full-range random, 2 all max, 3 max x min, 4 shift rounding
  function automatic int gen_pix(int mode);
    case (mode)
      0: return int'($urandom_range(8191)) - 4096;
      1: return int'($urandom);
      2, 3: return 32'h7fffffff;
      default: return -1;
    endcase
  endfunction

  function automatic int gen_w(int mode, int i);
    case (mode)
      0: return int'($urandom_range(2047)) - 1024;
      1: return int'($urandom);
      2: return 32'h7fffffff;
      3: return 32'h80000000;
      default: return (i == 0) ? 1 : 0;
    endcase
  endfunction

  task automatic load_a(int mode);
    for (int i = 0; i < NA*NA; i++) begin
      @(negedge clk); a_pwe = 1; a_paddr = 8'(i); sa_p[i] = gen_pix(mode); a_pdata = sa_p[i];
    end
    @(negedge clk); a_pwe = 0;
    for (int i = 0; i <= KA*KA; i++) begin
      @(negedge clk); a_cwe = 1; a_caddr = 5'(i);
      if (i == KA*KA) begin
        sa_b = (mode == 4) ? 100 : (mode == 0) ? int'($urandom_range(4095)) - 2048 : 0;
        a_cdata = sa_b;
      end else begin
        sa_w[i] = gen_w(mode, i); a_cdata = sa_w[i];
      end
    end
    @(negedge clk); a_cwe = 0;
  endtask

  task automatic load_b(int mode);
    for (int i = 0; i < NB*NB; i++) begin
      @(negedge clk); b_pwe = 1; b_paddr = 8'(i); sb_p[i] = gen_pix(mode); b_pdata = sb_p[i];
    end
    @(negedge clk); b_pwe = 0;
    for (int i = 0; i <= KB*KB; i++) begin
      @(negedge clk); b_cwe = 1; b_caddr = 5'(i);
      if (i == KB*KB) begin
        sb_b = (mode == 0) ? int'($urandom_range(4095)) - 2048 : 0;
        b_cdata = sb_b;
      end else begin
        sb_w[i] = gen_w(mode, i); b_cdata = sb_w[i];
      end
    end
    @(negedge clk); b_cwe = 0;
  endtask

  task automatic run_a(string t, bit extra_start);
    tag = t; a_cnt = 0; a_nd = 0;
    @(negedge clk); a_start = 1;
    @(negedge clk); a_start = 0;
    check("R6 busy after start", a_busy, 1);
    if (extra_start) begin
      repeat (60) @(negedge clk);
      a_start = 1; @(negedge clk); a_start = 0;
    end
    do @(negedge clk); while (!a_done);
    @(negedge clk);
    check({"R5 count ", t}, a_cnt, OWA*OWA);
    check({"R6 one done ", t}, a_nd, 1);
    check("R6 idle after done", a_busy, 0);
  endtask

  task automatic run_b(string t);
    tag = t; b_cnt = 0; b_nd = 0;
    @(negedge clk); b_start = 1;
    @(negedge clk); b_start = 0;
    do @(negedge clk); while (!b_done);
    @(negedge clk);
    check({"R9 count ", t}, b_cnt, OWB*OWB);
    check({"R9 one done ", t}, b_nd, 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R8 valid reset", a_ov, 0);
    check("R8 done reset", a_done, 0);
    check("R8 busy reset", a_busy, 0);
    check("R8 busy reset k4", b_busy, 0);
    rst_n = 1;
    load_a(4); run_a("R1 shift rounding", 0);
    load_a(0); run_a("R2 random small", 0);
    load_a(0); run_a("R7 start while busy", 1);
    load_a(1); run_a("R3 full range clamp", 0);
    load_a(2); run_a("R3 positive clamp", 0);
    load_a(3); run_a("R4 negative clamp rectified", 0);
    load_b(0); run_b("R2 random small");
    load_b(1); run_b("R3 full range clamp");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", LIMIT);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule